// File: doc/BRIEF.md
# Receive Word Boundary Aligner

This block sits after a deserializer. It receives one parallel word per clock. The incoming bits form a continuous stream whose word boundary falls at an arbitrary bit position. The block keeps a short history of recent words and treats it as a bit window. It places a boundary inside that window and presents the re-framed word on a registered output. Bit 0 of every word is the earliest received bit.

There are two ways to choose the boundary.

- **Bit-slip mode:** a rising edge on an external slip request moves the boundary one bit later. This discards the oldest bit still pending. A receiver training loop can walk the boundary until the framing is right.
- **Pattern mode:** a rising edge on an alignment request arms a search for a programmable pattern. The pattern can be 7, 8, 10, 16, 20, 32 or 40 bits long, and its first-received bit is held in the least significant position. The boundary locks at the first place the pattern appears and then stays fixed until another request edge arrives.

Both request inputs pass through a synchroniser before edge detection. A one-cycle flag marks every output word whose leading bits carry the pattern.

Top module: `rx_word_framer`

## Requirements
- R1: While reset is high and on the first cycle after it, the block drives `data_out`, `pat_det` and `aligned` to zero, and the bit offset returns to 0.
- R2: With the default two-word window, the word registered at clock edge n comes from the concatenation of the words captured at edges n-2 (low bits) and n-1. It starts at the current bit offset, and the earliest received bit lands in bit 0.
- R3: In bit-slip mode (`mode_manual`=0), `slip_req` passes through a two-flop synchroniser. A rising edge first seen high at edge k increments the offset at edge k+2. The output built from the new offset appears at edge k+3 and starts one bit later in the stream.
- R4: Holding `slip_req` high, or holding it low, causes no further boundary movement. Only rising edges count.
- R5: The offset wraps from DW-1 back to 0.
- R6: In pattern mode (`mode_manual`=1), `slip_req` has no effect on the boundary.
- R7: A synchronised rising edge of `align_req` arms the search and clears `aligned`. While the search is armed, the block takes the lowest offset p (0 to DW-1) at which window bits p to p+PL-1 equal the pattern, with pattern bit 0 compared to the earliest bit. At that edge the offset becomes p, `aligned` rises, and the output word is taken from offset p.
- R8: Once locked, the boundary stays fixed until the next rising edge of `align_req` or a reset. Keeping `align_req` high does not re-arm the search, even when the pattern moves.
- R9: `pat_det` is high for exactly those output words whose first PL bits, counted from the boundary used for that word, equal the pattern. This applies in both modes.
- R10: While `mode_manual` is 0, `aligned` is held low and any armed search is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_manual | input | 1 | 0 selects bit-slip mode, 1 selects pattern mode |
| rx_data | input | DW | Parallel word from the deserializer, bit 0 earliest |
| slip_req | input | 1 | Asynchronous bit-slip request, acted on at rising edges |
| align_req | input | 1 | Asynchronous pattern-search request, acted on at rising edges |
| data_out | output | DW | Re-framed word |
| pat_det | output | 1 | High for one word when the pattern sits at the boundary |
| aligned | output | 1 | High once the pattern search has locked |

## Verification
The hardest case to reach is a lock on a pattern that straddles two input words at a non-zero offset. Just as hard is keeping `align_req` held high while the pattern then moves to another offset, since the lock must not follow it. The bench builds its input as a bit queue rather than as whole words. Random prefixes of chosen length shift the pattern to any offset across word edges. The request is raised a few cycles before the pattern bits are queued, then held high while a second, shifted pattern train arrives. Only after that is it dropped and raised again to force a fresh lock.

// File: rtl/wafr_pkg.sv
package wafr_pkg;

  // Number of words the history must hold so that every offset 0..dw-1
  // can see both a full output word and a full pattern.
  function automatic int calc_words(input int dw, input int pl);
    int need;
    int words;
    need  = dw - 1 + ((pl > dw) ? pl : dw);
    words = (need + dw - 1) / dw;
    return (words < 2) ? 2 : words;
  endfunction

  function automatic int offset_bits(input int dw);
    return (dw > 1) ? $clog2(dw) : 1;
  endfunction

endpackage

// File: rtl/ctl_edge_sync.sv
module ctl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rx_bit_history.sv
module rx_bit_history #(
  parameter int DW = 10,
  parameter int NW = 2,
  localparam int WIN = DW * NW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  din,
  output logic [WIN-1:0] win
);

  // Oldest word sits in the low bits; each new word enters at the top.
  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {din, win[WIN-1:DW]};
  end

endmodule

// File: rtl/align_pattern_locator.sv
module align_pattern_locator #(
  parameter int          DW      = 10,
  parameter int          PL      = 10,
  parameter int          WIN     = 20,
  parameter logic [39:0] PATTERN = 40'h17C,
  localparam int         OW      = wafr_pkg::offset_bits(DW)
) (
  input  logic [WIN-1:0] win,
  output logic [DW-1:0]  match_vec,
  output logic           hit,
  output logic [OW-1:0]  hit_pos
);

  localparam logic [PL-1:0] PAT = PATTERN[PL-1:0];

  for (genvar p = 0; p < DW; p++) begin : g_cmp
    assign match_vec[p] = (win[p +: PL] == PAT);
  end

  // Lowest offset wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int p = DW - 1; p >= 0; p--) begin
      if (match_vec[p]) begin
        hit     = 1'b1;
        hit_pos = OW'(p);
      end
    end
  end

endmodule

// File: rtl/rx_word_framer.sv
module rx_word_framer #(
  parameter int          DW          = 10,
  parameter int          PAT_LEN     = 10,
  parameter logic [39:0] PATTERN     = 40'h17C,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_manual,
  input  logic [DW-1:0] rx_data,
  input  logic          slip_req,
  input  logic          align_req,
  output logic [DW-1:0] data_out,
  output logic          pat_det,
  output logic          aligned
);

  localparam int NW  = wafr_pkg::calc_words(DW, PAT_LEN);
  localparam int WIN = NW * DW;
  localparam int OW  = wafr_pkg::offset_bits(DW);
  localparam logic [OW-1:0] OFF_LAST = OW'(DW - 1);

  logic           slip_rise;
  logic           align_rise;
  logic [WIN-1:0] win;
  logic [DW-1:0]  match_vec;
  logic           hit;
  logic [OW-1:0]  hit_pos;
  logic [OW-1:0]  slip_off;
  logic           armed;
  logic           lock_now;
  logic [OW-1:0]  eff_off;

  ctl_edge_sync #(.STAGES(SYNC_STAGES)) u_slip_sync (
    .clk (clk),
    .rst (rst),
    .din (slip_req),
    .rise(slip_rise)
  );

  ctl_edge_sync #(.STAGES(SYNC_STAGES)) u_align_sync (
    .clk (clk),
    .rst (rst),
    .din (align_req),
    .rise(align_rise)
  );

  rx_bit_history #(.DW(DW), .NW(NW)) u_hist (
    .clk(clk),
    .rst(rst),
    .din(rx_data),
    .win(win)
  );

  align_pattern_locator #(
    .DW(DW), .PL(PAT_LEN), .WIN(WIN), .PATTERN(PATTERN)
  ) u_locate (
    .win      (win),
    .match_vec(match_vec),
    .hit      (hit),
    .hit_pos  (hit_pos)
  );

  // A lock takes effect on the same edge that finds the pattern.
  assign lock_now = mode_manual & ~align_rise & armed & hit;
  assign eff_off  = lock_now ? hit_pos : slip_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_off <= '0;
      armed    <= 1'b0;
      aligned  <= 1'b0;
      data_out <= '0;
      pat_det  <= 1'b0;
    end else begin
      if (!mode_manual) begin
        armed   <= 1'b0;
        aligned <= 1'b0;
        if (slip_rise)
          slip_off <= (slip_off == OFF_LAST) ? '0 : slip_off + 1'b1;
      end else if (align_rise) begin
        armed   <= 1'b1;
        aligned <= 1'b0;
      end else if (lock_now) begin
        armed    <= 1'b0;
        aligned  <= 1'b1;
        slip_off <= hit_pos;
      end
      data_out <= win[eff_off +: DW];
      pat_det  <= match_vec[eff_off];
    end
  end

endmodule

// File: rtl/rx_word_framer_chk.sv
module rx_word_framer_chk #(
  parameter int          DW      = 10,
  parameter int          PL      = 10,
  parameter int          OW      = 4,
  parameter logic [39:0] PATTERN = 40'h17C
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_manual,
  input logic [DW-1:0] data_out,
  input logic          pat_det,
  input logic          aligned,
  input logic          armed,
  input logic          slip_rise,
  input logic [OW-1:0] slip_off
);

  assert_aligned_needs_manual_R10: assert property (
    @(posedge clk) disable iff (rst) !mode_manual |=> !aligned);

  assert_lock_from_armed_R7: assert property (
    @(posedge clk) disable iff (rst) $rose(aligned) |-> $past(armed));

  assert_boundary_hold_R8: assert property (
    @(posedge clk) disable iff (rst) (aligned && $past(aligned)) |-> $stable(slip_off));

  assert_manual_no_slip_R6: assert property (
    @(posedge clk) disable iff (rst)
      (mode_manual && $past(mode_manual) && !$rose(aligned)) |-> $stable(slip_off));

  assert_slip_step_R3: assert property (
    @(posedge clk) disable iff (rst)
      (slip_rise && !mode_manual && slip_off != OW'(DW - 1)) |=> (slip_off == $past(slip_off) + 1'b1));

  assert_slip_wrap_R5: assert property (
    @(posedge clk) disable iff (rst)
      (slip_rise && !mode_manual && slip_off == OW'(DW - 1)) |=> (slip_off == '0));

  if (PL <= DW) begin : g_det
    assert_det_carries_pattern_R9: assert property (
      @(posedge clk) disable iff (rst) pat_det |-> (data_out[PL-1:0] == PATTERN[PL-1:0]));
  end

endmodule

bind rx_word_framer rx_word_framer_chk #(
  .DW(DW), .PL(PAT_LEN), .OW(OW), .PATTERN(PATTERN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_manual(mode_manual),
  .data_out   (data_out),
  .pat_det    (pat_det),
  .aligned    (aligned),
  .armed      (armed),
  .slip_rise  (slip_rise),
  .slip_off   (slip_off)
);

// File: tb/rx_word_framer_bench.sv
module rx_word_framer_bench;

  localparam int          DW   = 10;
  localparam int          PL   = 10;
  localparam int          NW   = 2;
  localparam logic [39:0] PAT  = 40'h17C;
  localparam int          MAXW = 8192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_manual = 1'b0;
  logic          slip_req = 1'b0;
  logic          align_req = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] data_out;
  logic          pat_det;
  logic          aligned;

  always #4 clk = ~clk;

  rx_word_framer #(.DW(DW), .PAT_LEN(PL), .PATTERN(PAT)) u_rx_word_framer (
    .clk(clk), .rst(rst), .mode_manual(mode_manual), .rx_data(rx_data),
    .slip_req(slip_req), .align_req(align_req),
    .data_out(data_out), .pat_det(pat_det), .aligned(aligned)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    done   = 0;

  // Recorded stimulus, one entry per clock edge.
  logic [DW-1:0] rec_w [MAXW];
  bit            rec_s [MAXW];
  bit            rec_a [MAXW];
  int            n = 0;

  // Reference state and expectations.
  int            m_off = 0;
  bit            m_armed = 0;
  bit            m_aligned = 0;
  logic [DW-1:0] e_data = '0;
  bit            e_pat = 0;

  bit q[$];

  function automatic bit wbit(input int nn, input int i);
    int idx;
    idx = (nn - NW) * DW + i;
    if (idx < 0) return 1'b0;
    return rec_w[idx / DW][idx % DW];
  endfunction

  function automatic bit match_at(input int nn, input int p);
    for (int j = 0; j < PL; j++)
      if (wbit(nn, p + j) != PAT[j]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit sget(input int k, input bit is_align);
    if (k < 0) return 1'b0;
    return is_align ? rec_a[k] : rec_s[k];
  endfunction

  // Reference model, advanced once per clock edge.
  always @(posedge clk) begin
    bit sp, ap, found, lock;
    int pos, eff;
    if (n < MAXW) begin
      rec_w[n] = rst ? '0 : rx_data;
      rec_s[n] = rst ? 1'b0 : slip_req;
      rec_a[n] = rst ? 1'b0 : align_req;
      if (rst) begin
        m_off = 0; m_armed = 0; m_aligned = 0; e_data = '0; e_pat = 0;
      end else begin
        sp = sget(n - 2, 0) && !sget(n - 3, 0);
        ap = sget(n - 2, 1) && !sget(n - 3, 1);
        found = 0; pos = 0;
        for (int p = DW - 1; p >= 0; p--)
          if (match_at(n, p)) begin found = 1; pos = p; end
        lock = mode_manual && !ap && m_armed && found;
        eff  = lock ? pos : m_off;
        for (int i = 0; i < DW; i++) e_data[i] = wbit(n, eff + i);
        e_pat = match_at(n, eff);
        if (!mode_manual) begin
          m_armed = 0; m_aligned = 0;
          if (sp) m_off = (m_off == DW - 1) ? 0 : m_off + 1;
        end else if (ap) begin
          m_armed = 1; m_aligned = 0;
        end else if (lock) begin
          m_armed = 0; m_aligned = 1; m_off = pos;
        end
      end
      n++;
    end
  end

  // Stream driver: pops one word of bits per cycle.
  always @(negedge clk) begin
    logic [DW-1:0] w;
    while (q.size() < DW) q.push_back(1'($urandom));
    for (int i = 0; i < DW; i++) w[i] = q.pop_front();
    rx_data <= w;
  end

  // Compare outputs against the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (n > 0 && !done) begin
      checks++;
      if (data_out !== e_data) begin
        fails++;
        $display("FAIL %s data_out got %h exp %h (cycle %0d)", tag, data_out, e_data, n);
      end
      checks++;
      if (pat_det !== e_pat) begin
        fails++;
        $display("FAIL %s pat_det got %0b exp %0b (cycle %0d)", tag, pat_det, e_pat, n);
      end
      checks++;
      if (aligned !== m_aligned) begin
        fails++;
        $display("FAIL %s aligned got %0b exp %0b (cycle %0d)", tag, aligned, m_aligned, n);
      end
    end
  end

  task automatic push_rand(input int k);
    for (int i = 0; i < k; i++) q.push_back(1'($urandom));
  endtask

  task automatic push_pat(input int times);
    for (int t = 0; t < times; t++)
      for (int j = 0; j < PL; j++) q.push_back(PAT[j]);
  endtask

  task automatic slip_pulse(input int hi, input int lo);
    @(negedge clk) slip_req = 1'b1;
    repeat (hi) @(negedge clk);
    slip_req = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired during %s", tag);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R2: plain framing at offset 0
    tag = "R2";
    repeat (12) @(negedge clk);
    // R3: single slips
    tag = "R3";
    for (int i = 0; i < 3; i++) slip_pulse(4, 6);
    // R4: long levels
    tag = "R4";
    slip_pulse(25, 25);
    // R5: wrap through DW-1
    tag = "R5";
    for (int i = 0; i < DW + 2; i++) slip_pulse(3, 4);
    // R6: slips ignored in pattern mode
    tag = "R6";
    @(negedge clk) mode_manual = 1'b1;
    for (int i = 0; i < 3; i++) slip_pulse(3, 5);
    // R7: request edge then a pattern straddling words
    tag = "R7";
    @(negedge clk) align_req = 1'b1;
    repeat (5) @(negedge clk);
    @(posedge clk) begin push_rand(3); push_pat(12); end
    repeat (14) @(negedge clk);
    // R9: strobes while the pattern keeps arriving at the boundary
    tag = "R9";
    @(posedge clk) push_pat(6);
    repeat (10) @(negedge clk);
    // R8: request held high, pattern shifted, boundary must hold
    tag = "R8";
    @(posedge clk) begin push_rand(6); push_pat(10); end
    repeat (16) @(negedge clk);
    align_req = 1'b0;
    repeat (6) @(negedge clk);
    // R7: new edge relocks at the new offset
    tag = "R7";
    align_req = 1'b1;
    repeat (5) @(negedge clk);
    @(posedge clk) begin push_rand(7); push_pat(10); end
    repeat (16) @(negedge clk);
    align_req = 1'b0;
    // R10: leaving pattern mode drops the lock
    tag = "R10";
    @(negedge clk) mode_manual = 1'b0;
    repeat (8) @(negedge clk);
    @(negedge clk) mode_manual = 1'b1;
    align_req = 1'b1;
    repeat (5) @(negedge clk);
    mode_manual = 1'b0;
    @(posedge clk) push_pat(8);
    repeat (12) @(negedge clk);
    align_req = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule